// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block emits a counted train of configuration clock pulses (`dclk`) on request. A write to the count register starts a burst of exactly that many pulses. A sticky completion flag is raised when the last pulse has finished. Software or a hardware sequencer polls the flag and clears it by writing 1 to it. Each pulse is a divided copy of the block clock. Its high and low phases each last `cd_ratio + 1` clock cycles, which lets the pulse rate match how fast the attached data source can deliver one 16-bit word.

The burst reaches the pin only while `path_en` is high. When the enable drops, the output is forced low and the burst pauses in place. It resumes when the enable returns. A one-cycle strobe comes one cycle before every rising edge of `dclk`, so a data feeder can present the next word on that same edge. Free-standing bursts with no data attached (for example 256 or 2047 pulses, used to flush or to request reconfiguration) use the same mechanism.

Top module: `dclk_burst_gen`

## Requirements
- R1: Writing a nonzero value N to register address 0 produces exactly N rising edges on `dclk`. Every value up to 2^CNT_W-1 is accepted, so 0x7FF (2047) is supported with the default width.
- R2: `done` becomes 1 on the clock edge where the last pulse falls. From then on `busy` is 0, and `dclk` stays low whenever `busy` is 0.
- R3: A write to address 1 with bit 0 set clears `done`. A write to address 1 with bit 0 clear leaves `done` unchanged, and so does no write at all.
- R4: Writing 0 to address 0 sets `done` on the next edge, leaves `busy` at 0 and produces no pulse.
- R5: Each `dclk` pulse is high for exactly `cd_ratio + 1` clock cycles.
- R6: While `path_en` is 0, `dclk` is 0 and the remaining count does not change. The burst continues once `path_en` returns to 1.
- R7: Writing address 0 during a burst clears `done`, reloads the remaining count and restarts the pulse phase. Exactly the new count of pulses follows.
- R8: `pulse_stb` is high for one cycle per pulse, in the cycle that ends with the edge on which `dclk` rises. Over a burst, the number of strobes equals the number of pulses.
- R9: `reg_rdata` shows the remaining pulse count when `reg_addr` is 0. When `reg_addr` is 1 it shows `{busy, done}` in bits 1:0, with the upper bits zero.
- R10: After reset, `dclk`, `done`, `busy` and the remaining count are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, reference for `dclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = pulse count, 1 = status |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| path_en | input | 1 | Enables the clock output path |
| cd_ratio | input | RATIO_W | Half-period minus one, in clock cycles |
| dclk | output | 1 | Configuration clock output |
| pulse_stb | output | 1 | Strobe one cycle before each `dclk` rise |
| busy | output | 1 | A burst has pulses remaining |
| done | output | 1 | Sticky completion flag |

## Verification
A corrupted remaining count shows up at the ports within one burst. The number of `dclk` rises differs from the written value, or `done` arrives early or late, and the address 0 readback also shows the wrong value immediately. A wrong divider or phase bit shows up within one pulse as a high phase of the wrong length, or as a strobe that is not followed by a rising edge. A flag that is mishandled is visible on the cycle after the offending write.

// File: rtl/dclk_burst_gen.sv
module dclk_burst_gen #(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic               path_en,
  input  logic [RATIO_W-1:0] cd_ratio,
  output logic               dclk,
  output logic               pulse_stb,
  output logic               busy,
  output logic               done
);

  logic [CNT_W-1:0]   remain;
  logic [RATIO_W-1:0] div;
  logic               hi;

  wire load      = reg_wr && !reg_addr;
  wire clr       = reg_wr && reg_addr && reg_wdata[0];
  wire run       = busy && path_en;
  wire tick      = run && (div >= cd_ratio);
  wire last_fall = tick && hi && (remain == CNT_W'(1));

  assign busy      = remain != '0;
  assign dclk      = hi && path_en;
  assign pulse_stb = tick && !hi && !load;
  assign reg_rdata = reg_addr ? {{(CNT_W-2){1'b0}}, busy, done} : remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      div    <= '0;
      hi     <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      remain <= reg_wdata;
      div    <= cd_ratio;
      hi     <= 1'b0;
      done   <= (reg_wdata == '0);
    end else begin
      if (tick) begin
        div <= '0;
        hi  <= !hi;
        if (hi) remain <= remain - CNT_W'(1);
      end else if (run) begin
        div <= div + RATIO_W'(1);
      end
      if (last_fall)  done <= 1'b1;
      else if (clr)   done <= 1'b0;
    end
  end

endmodule

// File: rtl/dclk_burst_gen_chk.sv
module dclk_burst_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             path_en,
  input logic             dclk,
  input logic             pulse_stb,
  input logic             busy,
  input logic             done
);

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dclk); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reg_wr) |=> done); // R3

  AST_CLR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && reg_wr && reg_addr && !reg_wdata[0]) |=> done); // R3

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata == '0) |=> (done && !busy)); // R4

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en && busy && !(reg_wr && !reg_addr)) |=> busy); // R6

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata != '0) |=> (busy && !done)); // R7

  AST_STB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_stb |=> ($rose(dclk) || !path_en)); // R8

endmodule

bind dclk_burst_gen dclk_burst_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .path_en(path_en), .dclk(dclk),
  .pulse_stb(pulse_stb), .busy(busy), .done(done)
);

// File: tb/dclk_burst_gen_tb_top.sv
`timescale 1ns/1ps
module dclk_burst_gen_tb_top;
  localparam int CNT_W = 16;
  localparam int RATIO_W = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0, path_en = 1;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [RATIO_W-1:0] cd_ratio = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic dclk, pulse_stb, busy, done;

  always #2.5 clk = ~clk;

  dclk_burst_gen #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .path_en(path_en),
    .cd_ratio(cd_ratio), .dclk(dclk), .pulse_stb(pulse_stb),
    .busy(busy), .done(done));

  int checks = 0, errors = 0;
  int rises = 0, stbs = 0, hw = 0, exp_hw = 1, width_err = 0, gated_hi = 0;
  bit prev = 0, ended = 0;

  always @(negedge clk) begin
    if (dclk && !prev) rises++;
    if (dclk) hw++;
    else if (prev) begin
      if (hw != exp_hw) width_err++;
      hw = 0;
    end
    if (!path_en && dclk) gated_hi++;
    if (pulse_stb) stbs++;
    prev = dclk;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(bit a, int d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = CNT_W'(d);
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic clear_counts();
    rises = 0; stbs = 0; hw = 0; width_err = 0; prev = 0; gated_hi = 0;
  endtask

  task automatic wait_done();
    for (int g = 0; g < 40000 && !done; g++) @(negedge clk);
  endtask

  function automatic int rd_status(bit b, bit d);
    return {b, d};
  endfunction

  task automatic run_burst(int n, int r, string tag);
    cd_ratio = RATIO_W'(r); exp_hw = r + 1;
    wr(0, n);
    clear_counts();
    wait_done();
    @(negedge clk);
    chk(rises == n, {tag, " R1 pulse count"}, rises, n);
    chk(stbs == n, {tag, " R8 strobe count"}, stbs, n);
    chk(width_err == 0, {tag, " R5 high width"}, width_err, 0);
    chk(done && !busy && !dclk, {tag, " R2 done/busy"}, rd_status(busy, done), 1);
    reg_addr = 0; #0.1;
    chk(reg_rdata == 0, {tag, " R9 remaining readback"}, reg_rdata, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int held;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!dclk && !done && !busy && reg_rdata == 0, "R10 reset state",
        rd_status(busy, done), 0);

    run_burst(1, 0, "single");
    run_burst(256, 2, "flush256");
    run_burst(12'h7FF, 0, "req2047");

    reg_addr = 1; #0.1;
    chk(reg_rdata == 1, "R9 status readback", reg_rdata, 1);
    wr(1, 2);
    @(negedge clk);
    chk(done == 1, "R3 write 0 keeps done", done, 1);
    wr(1, 1);
    @(negedge clk);
    chk(done == 0, "R3 write 1 clears done", done, 0);

    clear_counts();
    wr(0, 0);
    @(negedge clk);
    chk(done && !busy, "R4 zero count done", rd_status(busy, done), 1);
    repeat (10) @(negedge clk);
    chk(rises == 0, "R4 zero count no pulse", rises, 0);

    cd_ratio = 1; exp_hw = 2;
    wr(0, 20);
    repeat (15) @(negedge clk);
    #0.5 path_en = 0;
    @(negedge clk);
    reg_addr = 0; #0.1;
    held = reg_rdata;
    repeat (30) @(negedge clk);
    #0.1;
    chk(reg_rdata == held, "R6 count frozen", reg_rdata, held);
    chk(gated_hi == 0, "R6 dclk gated low", gated_hi, 0);
    chk(busy == 1, "R6 still busy", busy, 1);
    #0.5 path_en = 1;
    wait_done();
    chk(done == 1, "R6 resumes to done", done, 1);

    cd_ratio = 0; exp_hw = 1;
    wr(0, 30);
    repeat (20) @(negedge clk);
    wr(0, 5);
    clear_counts();
    chk(done == 0, "R7 reload clears done", done, 0);
    wait_done();
    @(negedge clk);
    chk(rises == 5, "R7 reload pulse count", rises, 5);

    for (int i = 0; i < 20; i++) begin
      run_burst(1 + int'($urandom_range(59)), int'($urandom_range(3)), "random");
    end
    finish_sim();
  end
endmodule